// File: doc/BRIEF.md
# Lane-Aliased General Register File

This block holds eight 32-bit general registers. A 2-bit size code picks the view for each access: a byte, a halfword or a full word. Halfword and word views map one index to one register. The byte view works differently. Indices 0 to 3 reach the least significant byte of registers 0 to 3. Indices 4 to 7 reach bits 15:8 of those same four registers, so no extra storage exists behind them.

The block has one combinational read port and one write port that updates on the clock edge. A narrow write changes only the lane it addresses and keeps every other bit of the register. An index that is out of range, or the reserved size code, raises an error flag. When the flag is set, the access reaches no register.

Top module: `lane_regfile`

## Requirements
- R1: Size code 0 selects the byte view. For a read index i below 4, rd_data_o equals bits 7:0 of register i, with zeros above.
- R2: In the byte view, a read index i from 4 to 7 returns bits 15:8 of register i-4 in bits 7:0 of rd_data_o, with zeros above.
- R3: A byte write to index i below 4 replaces bits 7:0 of register i with wr_data_i[7:0]. A byte write to index 4 to 7 replaces bits 15:8 of register i-4 with wr_data_i[7:0]. All other bits stay as they were.
- R4: Size code 1 selects the halfword view. A read returns bits 15:0 zero-extended. A write replaces bits 15:0 and keeps bits 31:16.
- R5: Size code 2 selects the word view, which reads or replaces all 32 bits.
- R6: In the halfword and word views, an index of 8 or more sets the error output. Size code 3 sets the error output for any index.
- R7: A write that raises the write error changes no register. While the read error is set, rd_data_o reads zero.
- R8: A write takes effect at the rising clock edge. A read in the same cycle returns the old contents.
- R9: Reset, active low and asynchronous, clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rd_idx_i | input | 4 | read index |
| rd_size_i | input | 2 | read view: 0 byte, 1 halfword, 2 word |
| rd_data_o | output | 32 | zero-extended read data |
| rd_err_o | output | 1 | illegal read index or size |
| wr_en_i | input | 1 | write request |
| wr_idx_i | input | 4 | write index |
| wr_size_i | input | 2 | write view |
| wr_data_i | input | 32 | write data, right-aligned |
| wr_err_o | output | 1 | illegal write request, write dropped |

## Verification
The bench aims at the aliasing of byte indices 4 to 7. A design that mapped them to separate storage, or to the low byte, would return the wrong lane or overwrite bits 7:0. The bench also checks that narrow writes keep the untouched bits: a design that zero-filled or sign-filled the upper bits would show them changed on a later word read. It also issues illegal writes (index 8 or more, or size code 3) and checks that a design which still wrote would show a changed register. Finally, it reads and writes the same register in one cycle, so a design with write-through would show the new value too early.

// File: rtl/lane_regfile_pkg.sv
package lane_regfile_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } view_e;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_regfile_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int IDXW  = 4
) (
  input  logic [IDXW-1:0]          idx_i,
  input  logic [1:0]               size_i,
  output logic [$clog2(NREGS)-1:0] reg_o,
  output logic                     hi_byte_o,
  output logic                     err_o
);
  localparam int RW   = $clog2(NREGS);
  localparam int HALF = NREGS / 2;

  always_comb begin
    reg_o     = idx_i[RW-1:0];
    hi_byte_o = 1'b0;
    err_o     = 1'b0;
    unique case (view_e'(size_i))
      SZ_BYTE: begin
        if (int'(idx_i) >= NREGS) err_o = 1'b1;
        else if (int'(idx_i) >= HALF) begin
          hi_byte_o = 1'b1;
          reg_o     = RW'(int'(idx_i) - HALF);
        end
      end
      SZ_HALF, SZ_WORD: err_o = (int'(idx_i) >= NREGS);
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
  import lane_regfile_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int IDXW  = 4,
  parameter int DW    = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] rd_idx_i,
  input  logic [1:0]      rd_size_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_err_o,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [1:0]      wr_size_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic            wr_err_o
);
  localparam int RW = $clog2(NREGS);

  logic [DW-1:0] regs_q [NREGS];
  logic [RW-1:0] rd_reg, wr_reg;
  logic          rd_hi, wr_hi, wr_bad;

  lane_decode #(.NREGS(NREGS), .IDXW(IDXW)) i_rd_dec (
    .idx_i(rd_idx_i), .size_i(rd_size_i),
    .reg_o(rd_reg), .hi_byte_o(rd_hi), .err_o(rd_err_o));

  lane_decode #(.NREGS(NREGS), .IDXW(IDXW)) i_wr_dec (
    .idx_i(wr_idx_i), .size_i(wr_size_i),
    .reg_o(wr_reg), .hi_byte_o(wr_hi), .err_o(wr_bad));

  assign wr_err_o = wr_en_i & wr_bad;

  always_comb begin
    rd_data_o = '0;
    if (!rd_err_o) begin
      unique case (view_e'(rd_size_i))
        SZ_BYTE: rd_data_o[7:0] = rd_hi ? regs_q[rd_reg][15:8] : regs_q[rd_reg][7:0];
        SZ_HALF: rd_data_o[15:0] = regs_q[rd_reg][15:0];
        default: rd_data_o = regs_q[rd_reg];
      endcase
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && !wr_bad && (wr_reg == RW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (hit) begin
        unique case (view_e'(wr_size_i))
          SZ_BYTE: begin
            if (wr_hi) regs_q[g][15:8] <= wr_data_i[7:0];
            else       regs_q[g][7:0]  <= wr_data_i[7:0];
          end
          SZ_HALF: regs_q[g][15:0] <= wr_data_i[15:0];
          default: regs_q[g] <= wr_data_i;
        endcase
      end
    end
  end

  // R7
  rd_err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_data_o == '0);
  // R7
  wr_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> regs_q[0] == $past(regs_q[0]) && regs_q[NREGS-1] == $past(regs_q[NREGS-1]));
  // R6
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_size_i == 2'd3) |-> rd_err_o);
  // R3
  byte_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd0 && wr_idx_i == 4'd4) |=> regs_q[0][7:0] == $past(regs_q[0][7:0]) && regs_q[0][31:16] == $past(regs_q[0][31:16]));
  // R4
  half_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd1 && wr_idx_i == 4'd1) |=> $stable(regs_q[1][31:16]));
  // R1
  narrow_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_size_i == 2'd0) |-> rd_data_o[31:8] == '0);
endmodule

// File: tb/test_lane_regfile.sv
module test_lane_regfile;
  logic clk_i = 0, rst_ni = 0;
  logic [3:0] rd_idx_i = 0, wr_idx_i = 0;
  logic [1:0] rd_size_i = 2, wr_size_i = 2;
  logic [31:0] rd_data_o, wr_data_i = 0;
  logic rd_err_o, wr_err_o, wr_en_i = 0;
  int checks = 0, fails = 0;
  logic [31:0] model [8];

  always #10 clk_i = ~clk_i;

  lane_regfile i_lane_regfile (.*);

  // {wr_size, wr_idx, wr_data, rd_size, rd_idx, expected rd_data}
  typedef struct packed {
    logic [1:0] ws; logic [3:0] wi; logic [31:0] wd;
    logic [1:0] rs; logic [3:0] ri; logic [31:0] exp;
  } vec_t;
  localparam vec_t VECS [10] = '{
    '{2'd2, 4'd0, 32'h11223344, 2'd2, 4'd0, 32'h11223344}, // R5
    '{2'd0, 4'd4, 32'hFFFFFFAB, 2'd2, 4'd0, 32'h1122AB44}, // R3 hi lane
    '{2'd0, 4'd0, 32'h000000CD, 2'd2, 4'd0, 32'h1122ABCD}, // R3 lo lane
    '{2'd0, 4'd0, 32'h0,        2'd0, 4'd4, 32'h000000AB}, // R2
    '{2'd2, 4'd3, 32'hDEADBEEF, 2'd0, 4'd3, 32'h000000EF}, // R1
    '{2'd0, 4'd7, 32'h00000055, 2'd2, 4'd3, 32'hDEAD55EF}, // R3 idx7
    '{2'd1, 4'd3, 32'hAAAA1234, 2'd2, 4'd3, 32'hDEAD1234}, // R4
    '{2'd1, 4'd3, 32'h0,        2'd1, 4'd3, 32'h00001234}, // R4 read
    '{2'd2, 4'd7, 32'hCAFEF00D, 2'd2, 4'd7, 32'hCAFEF00D}, // R5 idx7
    '{2'd0, 4'd3, 32'h0,        2'd0, 4'd7, 32'h00000012}  // R2 idx7
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [3:0] i, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_size_i = s; wr_idx_i = i; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(logic [1:0] s, logic [3:0] i);
    rd_size_i = s; rd_idx_i = i; #1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #25 rst_ni = 1;
    for (int r = 0; r < 8; r++) begin
      @(negedge clk_i); rd(2'd2, 4'(r));
      chk("R9 reset", rd_data_o, 32'h0);
    end
    for (int v = 0; v < 10; v++) begin
      if (VECS[v].wd != 0 || VECS[v].ws == 2) wr(VECS[v].ws, VECS[v].wi, VECS[v].wd);
      rd(VECS[v].rs, VECS[v].ri);
      chk($sformatf("R1-5 vec%0d", v), rd_data_o, VECS[v].exp);
    end
    // R6 / R7: illegal writes ignored
    @(negedge clk_i);
    wr_en_i = 1; wr_size_i = 2'd3; wr_idx_i = 4'd0; wr_data_i = 32'h0;
    #1 chk("R6 size3 werr", {31'b0, wr_err_o}, 32'd1);
    @(negedge clk_i);
    wr_size_i = 2'd2; wr_idx_i = 4'd8; #1;
    chk("R6 idx8 werr", {31'b0, wr_err_o}, 32'd1);
    @(negedge clk_i);
    wr_size_i = 2'd0; wr_idx_i = 4'd12; #1;
    chk("R6 byte idx12 werr", {31'b0, wr_err_o}, 32'd1);
    @(negedge clk_i); wr_en_i = 0;
    rd(2'd2, 4'd0); chk("R7 reg0 kept", rd_data_o, 32'h1122ABCD);
    rd(2'd2, 4'd7); chk("R7 reg7 kept", rd_data_o, 32'hCAFEF00D);
    rd(2'd3, 4'd0);
    chk("R6 rd size3 err", {31'b0, rd_err_o}, 32'd1);
    chk("R7 rd err zero", rd_data_o, 32'h0);
    rd(2'd1, 4'd9);
    chk("R6 rd idx9 err", {31'b0, rd_err_o}, 32'd1);
    // R8: same-cycle read shows old value
    @(negedge clk_i);
    wr_en_i = 1; wr_size_i = 2'd2; wr_idx_i = 4'd5; wr_data_i = 32'h5A5A5A5A;
    rd(2'd2, 4'd5);
    chk("R8 old value", rd_data_o, 32'h0);
    @(negedge clk_i); wr_en_i = 0; #1;
    chk("R8 new value", rd_data_o, 32'h5A5A5A5A);
    // R9: async reset clears
    #3 rst_ni = 0; #1;
    chk("R9 async clear", rd_data_o, 32'h0);
    @(negedge clk_i); rst_ni = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule